// File: doc/BRIEF.md
# Versatile Interface Adapter Core

This block is an 8-bit peripheral adapter that a processor reaches through a byte-wide register interface with a 4-bit register select. It provides two 8-bit ports. Each port has a data register and a direction register. Reads of a port combine the data register bits that drive out with the pin levels of the bits that are inputs.

It has two 16-bit down-counters. The first has a reload latch and can run as a one-shot or as a free-running interval timer. The second is always one-shot. The timers step once for each cycle in which the clock-enable input `tick` is high. The core also holds an auxiliary control byte, a peripheral control byte and a shift holding byte, all of which read back as written.

A 7-bit flag register and a 7-bit enable register combine into one active-high interrupt output. The two timers and a set of external level inputs set flag bits. Software sets or clears flag and enable bits in groups, and bit 7 of the written byte chooses which.

Top module: `via_core`

## Requirements
- R1: The register select decodes as follows: 0 port B data, 1 port A data (alias), 2 port B direction, 3 port A direction, 4 timer 1 count low, 5 timer 1 count high, 6 timer 1 latch low, 7 timer 1 latch high, 8 timer 2 count low, 9 timer 2 count high, 10 shift byte, 11 auxiliary control, 12 peripheral control, 13 flags, 14 enables, 15 port A data. The shift, auxiliary and peripheral bytes read back as last written.
- R2: A port data write changes only the bits whose direction bit is 1. A port read returns the data register bit where direction is 1 and the input pin where direction is 0. The `pa_out`/`pb_out` outputs show the full data register, and `pa_oe`/`pb_oe` show the direction register.
- R3: A write to the flag (13) or enable (14) register with data bit 7 = 1 sets every bit i (0..6) whose data bit i is 1. With bit 7 = 0, it clears those bits. Other bits are unchanged.
- R4: A flag read returns bit 7 as the OR of flags 6:0. An enable read always returns bit 7 as 1.
- R5: `irq` is 1 exactly when some flag bit and the same enable bit are both 1. It is updated on the same edge as the flags.
- R6: A timer count-low write is only held and does not change the counter. A count-high write loads {high, held low} and starts the timer. A timer loaded with N (N at least 1) expires on the N-th tick after the load. On expiry the timer sets its flag: timer 1 sets bit 6 and timer 2 sets bit 5. A timer loaded with 0 expires on the first tick.
- R7: When auxiliary bits 7:6 = 01, timer 1 reloads from its latch on expiry and keeps running. A write to latch high (7) stores the latch and restarts timer 1 from the full latch value.
- R8: In one-shot mode (timer 1 with auxiliary bits 7:6 other than 01, and timer 2 always), a timer raises its flag once. It then stops at count 0 until it is reloaded.
- R9: External input i (bit i of `ext_irq`, i < 5) sets flag bit i to its new level whenever that input changes. Between changes, software writes rule the bit.
- R10: After reset every register, counter, latch and hold byte reads 0, except bit 7 of an enable read. Read data appears on `rdata` on the clock edge that samples the read.
- R11: Timer counters do not change in cycles where `tick` is 0 and no timer register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| sel | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A data register |
| pa_oe | output | 8 | Port A direction (1 = drive) |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B data register |
| pb_oe | output | 8 | Port B direction (1 = drive) |
| tick | input | 1 | Timer clock enable |
| ext_irq | input | 5 | External interrupt levels |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the point where the timer counts run out. A counter that expired one tick late or early would raise its flag on the wrong tick. A one-shot timer that did not stop would flag again on later ticks, and a free-running timer that failed to reload would stay quiet. Randomized direction masks catch a port write that overwrote input-direction bits. They also catch a read that returned the register instead of the pin. Random set and clear writes to the enable register catch a design that ignored bit 7 or cleared bits it was not asked to. The external-input sequence clears a flag while its input is still high. That shows the flag follows changes and not the raw level.

// File: rtl/via_pkg.sv
package via_pkg;
  localparam int DW     = 8;
  localparam int SEL_W  = 4;
  localparam int NREG   = 1 << SEL_W;
  localparam int NFLAG  = 7;
  localparam int FLAG_T1 = 6;
  localparam int FLAG_T2 = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_PB   = 4'd0,  SEL_PAH  = 4'd1,  SEL_DDRB = 4'd2,  SEL_DDRA = 4'd3,
    SEL_T1CL = 4'd4,  SEL_T1CH = 4'd5,  SEL_T1LL = 4'd6,  SEL_T1LH = 4'd7,
    SEL_T2CL = 4'd8,  SEL_T2CH = 4'd9,  SEL_SHFT = 4'd10, SEL_AUX  = 4'd11,
    SEL_PER  = 4'd12, SEL_FLAG = 4'd13, SEL_ENA  = 4'd14, SEL_PA   = 4'd15
  } via_sel_e;
endpackage

// File: rtl/via_port.sv
module via_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_dat,
  input  logic         wr_ddr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] ddr_q,
  output logic [W-1:0] rd_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;
      ddr_q <= '0;
    end else begin
      if (wr_ddr) ddr_q <= wdata;
      if (wr_dat) dat_q <= (dat_q & ~ddr_q) | (wdata & ddr_q);
    end
  end

  assign rd_val = (dat_q & ddr_q) | (pin_in & ~ddr_q);
endmodule

// File: rtl/via_timer.sv
module via_timer #(
  parameter int DW     = 8,
  parameter bit RELOAD = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [DW-1:0]  wdata,
  input  logic           wr_cnt_lo,
  input  logic           wr_cnt_hi,
  input  logic           wr_lat_lo,
  input  logic           wr_lat_hi,
  input  logic           cont,
  output logic [2*DW-1:0] count,
  output logic [2*DW-1:0] latch,
  output logic           running,
  output logic           expire
);
  localparam int CW = 2 * DW;

  logic [DW-1:0] lo_hold;
  logic          restart;
  logic          at_end;

  generate
    if (RELOAD) begin : g_latch
      always_ff @(posedge clk) begin
        if (rst) latch <= '0;
        else begin
          if (wr_lat_lo) latch[DW-1:0]  <= wdata;
          if (wr_lat_hi) latch[CW-1:DW] <= wdata;
        end
      end
      assign restart = wr_lat_hi;
    end else begin : g_nolatch
      logic unused_lat;
      assign unused_lat = wr_lat_lo ^ wr_lat_hi;
      assign latch   = '0;
      assign restart = 1'b0;
    end
  endgenerate

  assign at_end = (count == CW'(0)) || (count == CW'(1));
  assign expire = tick && running && at_end && !wr_cnt_hi && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_hold <= '0;
      count   <= '0;
      running <= 1'b0;
    end else begin
      if (wr_cnt_lo) lo_hold <= wdata;
      if (wr_cnt_hi) begin
        count   <= {wdata, lo_hold};
        running <= 1'b1;
      end else if (restart) begin
        count   <= {wdata, latch[DW-1:0]};
        running <= 1'b1;
      end else if (tick && running) begin
        if (at_end) begin
          if (RELOAD && cont) count <= latch;
          else begin
            count   <= '0;
            running <= 1'b0;
          end
        end else begin
          count <= count - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/via_irq.sv
module via_irq #(
  parameter int NFLAG = 7,
  parameter int NEXT  = 5,
  parameter int T1B   = 6,
  parameter int T2B   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_flag,
  input  logic             wr_ena,
  input  logic [NFLAG:0]   wdata,
  input  logic [NEXT-1:0]  ext_lvl,
  input  logic             t1_exp,
  input  logic             t2_exp,
  output logic [NFLAG-1:0] flag_q,
  output logic [NFLAG-1:0] ena_q,
  output logic             irq
);
  logic [NEXT-1:0]  ext_prev;
  logic [NFLAG-1:0] hw_chg, hw_val, flag_sw, flag_d, ena_d;

  function automatic logic [NFLAG-1:0] set_clr(input logic [NFLAG-1:0] cur,
                                               input logic [NFLAG:0] d);
    return d[NFLAG] ? (cur | d[NFLAG-1:0]) : (cur & ~d[NFLAG-1:0]);
  endfunction

  always_comb begin
    hw_chg = '0;
    hw_val = '0;
    hw_chg[NEXT-1:0] = ext_lvl ^ ext_prev;
    hw_val[NEXT-1:0] = ext_lvl;
    hw_chg[T1B] = hw_chg[T1B] | t1_exp;
    hw_val[T1B] = hw_val[T1B] | t1_exp;
    hw_chg[T2B] = hw_chg[T2B] | t2_exp;
    hw_val[T2B] = hw_val[T2B] | t2_exp;
    flag_sw = wr_flag ? set_clr(flag_q, wdata) : flag_q;
    flag_d  = (flag_sw & ~hw_chg) | (hw_val & hw_chg);
    ena_d   = wr_ena ? set_clr(ena_q, wdata) : ena_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev <= '0;
      flag_q   <= '0;
      ena_q    <= '0;
      irq      <= 1'b0;
    end else begin
      ext_prev <= ext_lvl;
      flag_q   <= flag_d;
      ena_q    <= ena_d;
      irq      <= |(flag_d & ena_d);
    end
  end
endmodule

// File: rtl/via_core.sv
module via_core
  import via_pkg::*;
#(
  parameter int NEXT = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs,
  input  logic            we,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [DW-1:0]   pa_in,
  output logic [DW-1:0]   pa_out,
  output logic [DW-1:0]   pa_oe,
  input  logic [DW-1:0]   pb_in,
  output logic [DW-1:0]   pb_out,
  output logic [DW-1:0]   pb_oe,
  input  logic            tick,
  input  logic [NEXT-1:0] ext_irq,
  output logic            irq
);
  localparam int CW = 2 * DW;
  localparam int NPORT = 2;

  logic [NREG-1:0] wr_hit;
  assign wr_hit = (cs && we) ? (NREG'(1) << sel) : '0;

  // index 0 = port B, index 1 = port A
  logic [DW-1:0] p_pin [NPORT];
  logic [DW-1:0] p_dat [NPORT];
  logic [DW-1:0] p_ddr [NPORT];
  logic [DW-1:0] p_rd  [NPORT];
  logic          p_wd  [NPORT];
  logic          p_wr  [NPORT];

  assign p_pin[0] = pb_in;
  assign p_pin[1] = pa_in;
  assign p_wd[0]  = wr_hit[SEL_PB];
  assign p_wd[1]  = wr_hit[SEL_PA] | wr_hit[SEL_PAH];
  assign p_wr[0]  = wr_hit[SEL_DDRB];
  assign p_wr[1]  = wr_hit[SEL_DDRA];

  generate
    for (genvar i = 0; i < NPORT; i++) begin : g_port
      via_port #(.W(DW)) u_port (
        .clk(clk), .rst(rst), .wr_dat(p_wd[i]), .wr_ddr(p_wr[i]),
        .wdata(wdata), .pin_in(p_pin[i]),
        .dat_q(p_dat[i]), .ddr_q(p_ddr[i]), .rd_val(p_rd[i])
      );
    end
  endgenerate

  assign pb_out = p_dat[0];
  assign pb_oe  = p_ddr[0];
  assign pa_out = p_dat[1];
  assign pa_oe  = p_ddr[1];

  logic [DW-1:0] aux_q, per_q, shft_q;
  logic          cont;

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_q  <= '0;
      per_q  <= '0;
      shft_q <= '0;
    end else begin
      if (wr_hit[SEL_AUX])  aux_q  <= wdata;
      if (wr_hit[SEL_PER])  per_q  <= wdata;
      if (wr_hit[SEL_SHFT]) shft_q <= wdata;
    end
  end

  assign cont = (aux_q[DW-1:DW-2] == 2'b01);

  logic [CW-1:0] t1_count, t1_latch, t2_count, t2_latch;
  logic          t1_run, t1_exp, t2_run, t2_exp;

  via_timer #(.DW(DW), .RELOAD(1'b1)) u_t1 (
    .clk(clk), .rst(rst), .tick(tick), .wdata(wdata),
    .wr_cnt_lo(wr_hit[SEL_T1CL]), .wr_cnt_hi(wr_hit[SEL_T1CH]),
    .wr_lat_lo(wr_hit[SEL_T1LL]), .wr_lat_hi(wr_hit[SEL_T1LH]),
    .cont(cont), .count(t1_count), .latch(t1_latch),
    .running(t1_run), .expire(t1_exp)
  );

  via_timer #(.DW(DW), .RELOAD(1'b0)) u_t2 (
    .clk(clk), .rst(rst), .tick(tick), .wdata(wdata),
    .wr_cnt_lo(wr_hit[SEL_T2CL]), .wr_cnt_hi(wr_hit[SEL_T2CH]),
    .wr_lat_lo(1'b0), .wr_lat_hi(1'b0),
    .cont(1'b0), .count(t2_count), .latch(t2_latch),
    .running(t2_run), .expire(t2_exp)
  );

  logic [NFLAG-1:0] flag_q, ena_q;

  via_irq #(.NFLAG(NFLAG), .NEXT(NEXT), .T1B(FLAG_T1), .T2B(FLAG_T2)) u_irq (
    .clk(clk), .rst(rst),
    .wr_flag(wr_hit[SEL_FLAG]), .wr_ena(wr_hit[SEL_ENA]),
    .wdata(wdata), .ext_lvl(ext_irq),
    .t1_exp(t1_exp), .t2_exp(t2_exp),
    .flag_q(flag_q), .ena_q(ena_q), .irq(irq)
  );

  logic [DW-1:0] rd_mux;
  logic          unused_t2l;
  assign unused_t2l = ^t2_latch;

  always_comb begin
    unique case (via_sel_e'(sel))
      SEL_PB:   rd_mux = p_rd[0];
      SEL_PAH,
      SEL_PA:   rd_mux = p_rd[1];
      SEL_DDRB: rd_mux = p_ddr[0];
      SEL_DDRA: rd_mux = p_ddr[1];
      SEL_T1CL: rd_mux = t1_count[DW-1:0];
      SEL_T1CH: rd_mux = t1_count[CW-1:DW];
      SEL_T1LL: rd_mux = t1_latch[DW-1:0];
      SEL_T1LH: rd_mux = t1_latch[CW-1:DW];
      SEL_T2CL: rd_mux = t2_count[DW-1:0];
      SEL_T2CH: rd_mux = t2_count[CW-1:DW];
      SEL_SHFT: rd_mux = shft_q;
      SEL_AUX:  rd_mux = aux_q;
      SEL_PER:  rd_mux = per_q;
      SEL_FLAG: rd_mux = {|flag_q, flag_q};
      SEL_ENA:  rd_mux = {1'b1, ena_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (cs && !we) rdata <= rd_mux;
  end
endmodule

// File: rtl/via_core_chk.sv
module via_core_chk #(
  parameter int DW = 8,
  parameter int NFLAG = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             cs,
  input logic             we,
  input logic [3:0]       sel,
  input logic [DW-1:0]    rdata,
  input logic [DW-1:0]    pb_out,
  input logic [DW-1:0]    pb_oe,
  input logic             tick,
  input logic             irq,
  input logic [2*DW-1:0]  t1_cnt,
  input logic             t1_run,
  input logic             t1_exp,
  input logic             t2_run,
  input logic             t2_exp,
  input logic             cont,
  input logic [NFLAG-1:0] flag,
  input logic [NFLAG-1:0] ena
);
  AST_PORT_KEEP: assert property (@(posedge clk) disable iff (rst) (cs && we && sel == 4'd0) |=> ((pb_out & ~$past(pb_oe)) == ($past(pb_out) & ~$past(pb_oe)))); // R2
  AST_ENA_TOP_BIT: assert property (@(posedge clk) disable iff (rst) (cs && !we && sel == 4'd14) |=> rdata[DW-1]); // R4
  AST_IRQ_NEEDS_ENA: assert property (@(posedge clk) disable iff (rst) (ena == '0) |-> !irq); // R5
  AST_T1_FLAG_SET: assert property (@(posedge clk) disable iff (rst) t1_exp |=> flag[6]); // R6
  AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (rst) (t1_exp && cont && !(cs && we)) |=> t1_run); // R7
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst) (t2_exp && !(cs && we)) |=> !t2_run); // R8
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst) (!tick && !(cs && we)) |=> $stable(t1_cnt)); // R11
endmodule

bind via_core via_core_chk #(.DW(via_pkg::DW), .NFLAG(via_pkg::NFLAG)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .we(we), .sel(sel), .rdata(rdata),
  .pb_out(pb_out), .pb_oe(pb_oe), .tick(tick), .irq(irq),
  .t1_cnt(t1_count), .t1_run(t1_run), .t1_exp(t1_exp),
  .t2_run(t2_run), .t2_exp(t2_exp), .cont(cont),
  .flag(flag_q), .ena(ena_q)
);

// File: tb/via_core_tb.sv
`timescale 1ns/1ps
module via_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, we = 1'b0;
  logic [3:0] sel = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pa_in = '0, pa_out, pa_oe, pb_in = '0, pb_out, pb_oe;
  logic       tick = 1'b0;
  logic [4:0] ext_irq = '0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  via_core u_dut (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .sel(sel), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .tick(tick),
    .ext_irq(ext_irq), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; sel = s;
    @(negedge clk);
    d = rdata;
    cs = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] set_clr(input logic [7:0] cur, input logic [7:0] d);
    return d[7] ? {1'b0, cur[6:0] | d[6:0]} : {1'b0, cur[6:0] & ~d[6:0]};
  endfunction

  function automatic logic [7:0] port_rd(input logic [7:0] r, input logic [7:0] ddr, input logic [7:0] pin);
    return (r & ddr) | (pin & ~ddr);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, ea, da, en, pin, seed;
    seed = 8'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    for (int s = 0; s < 16; s++) begin
      rd(4'(s), v);
      chk($sformatf("R10 reset sel %0d", s), v, (s == 14) ? 8'h80 : 8'h00);
    end
    chk("R10 reset irq", irq, 0);

    // R1 readback of plain bytes at their selects
    wr(4'd10, 8'h3C); wr(4'd11, 8'h00); wr(4'd12, 8'hC5); wr(4'd6, 8'h9A);
    rd(4'd10, v); chk("R1 shift", v, 8'h3C);
    rd(4'd12, v); chk("R1 periph", v, 8'hC5);
    rd(4'd6, v);  chk("R1 latch low", v, 8'h9A);
    rd(4'd7, v);  chk("R1 latch high", v, 8'h00);
    wr(4'd6, 8'h00);

    // R2 directed
    wr(4'd2, 8'h0F); wr(4'd0, 8'hAB);
    chk("R2 pb_out masked", pb_out, 8'h0B);
    pb_in = 8'h50;
    rd(4'd0, v); chk("R2 pb read mix", v, 8'h5B);
    wr(4'd2, 8'hFF);
    chk("R2 kept bits", pb_out, 8'h0B);
    chk("R2 pb_oe", pb_oe, 8'hFF);

    // R2 random on port A, via both aliases
    ea = 8'h00;
    for (int i = 0; i < 40; i++) begin
      da = 8'($urandom); v = 8'($urandom); pin = 8'($urandom);
      wr(4'd3, da);
      wr((i % 2) ? 4'd15 : 4'd1, v);
      ea = (ea & ~da) | (v & da);
      pa_in = pin;
      chk("R2 pa_out", pa_out, ea);
      rd(4'd15, v);
      chk("R2 pa read", v, port_rd(ea, da, pin));
    end

    // R3/R4 random enable set/clear
    en = 8'h00;
    for (int i = 0; i < 30; i++) begin
      v = 8'($urandom);
      wr(4'd14, v);
      en = set_clr(en, v);
      rd(4'd14, v);
      chk("R3 R4 enable", v, {1'b1, en[6:0]});
    end
    wr(4'd14, 8'h7F);

    // R3 R4 R5 software flags
    wr(4'd13, 8'h88);
    rd(4'd13, v); chk("R4 flag or bit", v, 8'h88);
    chk("R5 irq off without enable", irq, 0);
    wr(4'd14, 8'h88);
    chk("R5 irq on", irq, 1);
    wr(4'd14, 8'h08);
    chk("R5 irq off after disable", irq, 0);
    wr(4'd13, 8'h08);
    rd(4'd13, v); chk("R3 flag cleared", v, 8'h00);

    // R6 R8 R11 timer 1 one-shot
    wr(4'd11, 8'h00);
    wr(4'd4, 8'h05);
    rd(4'd4, v); chk("R6 low write held", v, 8'h00);
    wr(4'd5, 8'h00);
    rd(4'd4, v); chk("R6 loaded", v, 8'h05);
    repeat (10) @(negedge clk);
    rd(4'd4, v); chk("R11 no tick no change", v, 8'h05);
    ticks(4);
    rd(4'd13, v); chk("R6 no early flag", v, 8'h00);
    rd(4'd4, v); chk("R6 count after 4", v, 8'h01);
    ticks(1);
    rd(4'd13, v); chk("R6 flag on 5th tick", v, 8'hC0);
    wr(4'd13, 8'h40);
    ticks(3);
    rd(4'd13, v); chk("R8 one-shot no reflag", v, 8'h00);
    rd(4'd4, v); chk("R8 stopped at zero", v, 8'h00);

    // R7 continuous with latch restart
    wr(4'd11, 8'h40);
    wr(4'd6, 8'h02); wr(4'd7, 8'h00);
    rd(4'd4, v); chk("R7 restart from latch", v, 8'h02);
    ticks(2);
    rd(4'd13, v); chk("R7 first expiry", v, 8'hC0);
    rd(4'd4, v); chk("R7 reloaded", v, 8'h02);
    wr(4'd13, 8'h40);
    ticks(1);
    rd(4'd13, v); chk("R7 mid period", v, 8'h00);
    ticks(1);
    rd(4'd13, v); chk("R7 second expiry", v, 8'hC0);
    wr(4'd11, 8'h00);
    ticks(2);
    wr(4'd13, 8'h7F);
    ticks(2);
    rd(4'd13, v); chk("R8 stopped after mode change", v, 8'h00);

    // R6 R8 timer 2
    wr(4'd8, 8'h03); wr(4'd9, 8'h00);
    ticks(2);
    rd(4'd13, v); chk("R6 t2 early", v, 8'h00);
    ticks(1);
    rd(4'd13, v); chk("R6 t2 flag bit5", v, 8'hA0);
    wr(4'd13, 8'h20);
    ticks(3);
    rd(4'd13, v); chk("R8 t2 no reflag", v, 8'h00);
    rd(4'd8, v); chk("R8 t2 at zero", v, 8'h00);

    // R5 interrupt from timer 1, load of zero
    wr(4'd14, 8'hC0);
    wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    chk("R5 irq before expiry", irq, 0);
    ticks(1);
    chk("R6 R5 zero load expires first tick", irq, 1);
    wr(4'd14, 8'h40);
    chk("R5 irq dropped", irq, 0);
    wr(4'd13, 8'h7F);

    // R9 external levels
    wr(4'd14, 8'h84);
    @(negedge clk); ext_irq[2] = 1'b1;
    @(negedge clk);
    chk("R9 rise sets", irq, 1);
    rd(4'd13, v); chk("R9 flag bit2", v, 8'h84);
    wr(4'd13, 8'h04);
    rd(4'd13, v); chk("R9 cleared while high", v, 8'h00);
    @(negedge clk); ext_irq[2] = 1'b0;
    @(negedge clk);
    rd(4'd13, v); chk("R9 fall keeps 0", v, 8'h00);
    @(negedge clk); ext_irq[2] = 1'b1;
    @(negedge clk);
    rd(4'd13, v); chk("R9 second rise", v, 8'h84);
    @(negedge clk); ext_irq[2] = 1'b0;
    @(negedge clk);
    rd(4'd13, v); chk("R9 fall clears", v, 8'h00);
    chk("R9 irq low", irq, 0);

    if (seed === 8'hxx) $display("seed unset");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule